// File: doc/BRIEF.md
# Multiplexed LCD Waveform Sequencer

This block produces the drive selections for a passive liquid-crystal panel with 4 common lines and 32 segment lines. It holds the segment pattern in a small internal array, one 4-bit word per segment (bit k lights the pixel where that segment crosses common k). It scans the commons one after another and gives every pin an encoded bias-level select each clock. An external analog divider and pad stage turn these selects into voltages.

Four duty modes are available: static, 1/2, 1/3 and 1/4. Each mode has its own bias scheme. Drive polarity flips on every frame so that no pixel sees a net DC voltage. A frame-sync pulse and a display clock are output so that a second panel driver can track the scan. Any of the upper eight segment pins can be taken over one by one as a plain digital output.

Top module: `lcd_wave_seq`

## Requirements
- R1: While `disp_en` is low, and after reset, every common pin and every segment pin not in port mode drives code 0 (ground), and `fsync_o` and `dclk_o` are low. A drop of `disp_en` takes effect on the outputs one cycle later.
- R2: Level codes are 0 ground, 1 low intermediate, 2 middle intermediate, 3 top panel level, 4 supply. Commons are selected in ascending order, one slot of `CLK_DIV` cycles each. A frame is one slot per active common. In a positive frame the selected common drives code 3, and in a negative frame it drives code 0.
- R3: The first frame after `disp_en` rises is positive. Each later frame has the opposite polarity to the one before it.
- R4: At 1/4 duty (`duty_sel`=3, 1/3 bias), a non-selected common drives 1 (positive frame) or 2 (negative). A lit segment drives 0 (positive) or 3 (negative). An unlit segment drives 2 (positive) or 1 (negative).
- R5: At 1/2 duty (`duty_sel`=1, 1/2 bias), a non-selected common drives 2 in both polarities. A lit segment drives 0 (positive) or 3 (negative). An unlit segment drives the selected common's level, 3 (positive) or 0 (negative).
- R6: At 1/3 duty (`duty_sel`=2), `bias_third`=1 gives the R4 levels and `bias_third`=0 gives the R5 levels.
- R7: In static mode (`duty_sel`=0), a frame is a single slot and common 0 drives 3 (positive) or 0 (negative). A lit segment drives the opposite of common 0, and an unlit segment drives the same level as common 0.
- R8: A common that the current duty does not use drives the non-select level of the active bias. In static mode it follows common 0.
- R9: A write puts `wr_data` into the word for segment `wr_addr`. The change appears on the segment outputs from the second cycle after the write edge. A write that lands on a slot boundary therefore leaves the first cycle of the new slot with the old data.
- R10: When `port_sel[i]` is 1, segment pin 24+i drives 4 if `port_val[i]` is 1 and 0 otherwise, one cycle after the inputs. This holds whatever the value of `disp_en`.
- R11: `fsync_o` is high for the whole first slot of every frame and low during all other slots.
- R12: `dclk_o` is high for the first `CLK_DIV`/2 cycles of each slot and low for the rest.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| disp_en | input | 1 | Display enable; scan restarts when it rises |
| duty_sel | input | 2 | 0 static, 1 half, 2 third, 3 quarter duty |
| bias_third | input | 1 | Selects 1/3 bias in 1/3 duty |
| wr_en | input | 1 | Display word write strobe |
| wr_addr | input | 5 | Segment index to write |
| wr_data | input | 4 | Pixel bits, bit k for common k |
| port_sel | input | 8 | Per-pin port mode for segments 24..31 |
| port_val | input | 8 | Port data for segments 24..31 |
| com_lvl_o | output | 12 | 3-bit level code per common, common c at bits 3c+2..3c |
| seg_lvl_o | output | 96 | 3-bit level code per segment, segment s at bits 3s+2..3s |
| fsync_o | output | 1 | Frame start marker |
| dclk_o | output | 1 | Display clock, one period per slot |

## Verification
The risky overlap is a display write that lands on the same edge as a slot boundary. On that edge the scan moves to a new common and the pixel array changes together. The bench starts a 1/4-duty scan and drives a write to segment 3 during the last cycle of slot 0, so that the write edge is also the first edge of slot 1. It then expects the unlit level in the first cycle of slot 1 and the lit level from the next cycle on, as R9 states.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;

  typedef enum logic [2:0] {
    LV_VSS = 3'd0,
    LV_LC2 = 3'd1,
    LV_LC1 = 3'd2,
    LV_LC0 = 3'd3,
    LV_VDD = 3'd4
  } lvl_t;

  typedef enum logic [1:0] {
    SCH_STATIC = 2'd0,
    SCH_HALF   = 2'd1,
    SCH_THIRD  = 2'd2
  } scheme_t;

  // Common pin level for a given bias scheme, select state and frame polarity.
  function automatic lvl_t com_level(scheme_t sch, logic sel, logic neg);
    lvl_t lv;
    case (sch)
      SCH_HALF:  lv = sel ? (neg ? LV_VSS : LV_LC0) : LV_LC1;
      SCH_THIRD: lv = sel ? (neg ? LV_VSS : LV_LC0) : (neg ? LV_LC1 : LV_LC2);
      default:   lv = neg ? LV_VSS : LV_LC0;
    endcase
    return lv;
  endfunction

  // Segment pin level: lit pixels oppose the selected common.
  function automatic lvl_t seg_level(scheme_t sch, logic lit, logic neg);
    lvl_t lv;
    if (lit)
      lv = neg ? LV_LC0 : LV_VSS;
    else if (sch == SCH_THIRD)
      lv = neg ? LV_LC2 : LV_LC1;
    else
      lv = neg ? LV_VSS : LV_LC0;
    return lv;
  endfunction

endpackage

// File: rtl/lcd_slot_timer.sv
module lcd_slot_timer #(
  parameter int NUM_COM = 4,
  parameter int CLK_DIV = 8,
  localparam int SW = $clog2(NUM_COM),
  localparam int CW = $clog2(CLK_DIV)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic [SW-1:0] last_slot,
  output logic [CW-1:0] cnt,
  output logic [SW-1:0] slot,
  output logic          neg
);

  logic tick;
  assign tick = (cnt == CW'(CLK_DIV - 1));

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt  <= '0;
      slot <= '0;
      neg  <= 1'b0;
    end else if (tick) begin
      cnt <= '0;
      if (slot >= last_slot) begin
        slot <= '0;
        neg  <= ~neg;
      end else begin
        slot <= slot + 1'b1;
      end
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R3: frame wrap flips polarity and returns to slot 0
  a_r3_pol_flip: assert property (@(posedge clk) disable iff (rst)
    (run && tick && slot >= last_slot) |=> (!run || (slot == '0 && neg != $past(neg))));

  // R2: slot index only moves at the end of a slot
  a_r2_slot_hold: assert property (@(posedge clk) disable iff (rst)
    (run && !tick) |=> (!run || $stable(slot)));

endmodule

// File: rtl/lcd_disp_ram.sv
module lcd_disp_ram #(
  parameter int NUM_SEG = 32,
  parameter int NUM_COM = 4,
  localparam int AW = $clog2(NUM_SEG)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [AW-1:0]              wr_addr,
  input  logic [NUM_COM-1:0]         wr_data,
  output logic [NUM_SEG*NUM_COM-1:0] bits
);

  logic [NUM_COM-1:0] mem [NUM_SEG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_SEG; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[wr_addr] <= wr_data;
    end
  end

  for (genvar s = 0; s < NUM_SEG; s++) begin : g_flat
    assign bits[s*NUM_COM +: NUM_COM] = mem[s];
  end

  // R9: written word is held at the addressed location
  a_r9_write: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (mem[$past(wr_addr)] == $past(wr_data)));

endmodule

// File: rtl/lcd_pin_drive.sv
module lcd_pin_drive
  import lcd_seq_pkg::*;
#(
  parameter int NUM_COM  = 4,
  parameter int NUM_SEG  = 32,
  parameter int NUM_PORT = 8,
  parameter int CLK_DIV  = 8,
  localparam int SW = $clog2(NUM_COM),
  localparam int CW = $clog2(CLK_DIV),
  localparam int LW = 3,
  localparam int PORT_BASE = NUM_SEG - NUM_PORT
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       en,
  input  scheme_t                    sch,
  input  logic [SW-1:0]              last_slot,
  input  logic [CW-1:0]              cnt,
  input  logic [SW-1:0]              slot,
  input  logic                       neg,
  input  logic [NUM_SEG*NUM_COM-1:0] pix,
  input  logic [NUM_PORT-1:0]        port_sel,
  input  logic [NUM_PORT-1:0]        port_val,
  output logic [NUM_COM*LW-1:0]      com_lvl_o,
  output logic [NUM_SEG*LW-1:0]      seg_lvl_o,
  output logic                       fsync_o,
  output logic                       dclk_o
);

  logic [NUM_COM*LW-1:0] com_nx;
  logic [NUM_SEG*LW-1:0] seg_nx;

  for (genvar c = 0; c < NUM_COM; c++) begin : g_com
    logic used, sel;
    assign used = (SW'(c) <= last_slot);
    assign sel  = used && (slot == SW'(c));
    assign com_nx[c*LW +: LW] = en ? com_level(sch, sel, neg) : LV_VSS;
  end

  for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
    logic [NUM_COM-1:0] word;
    lvl_t               lcd_lv;
    assign word   = pix[s*NUM_COM +: NUM_COM];
    assign lcd_lv = en ? seg_level(sch, word[slot], neg) : LV_VSS;
    if (s >= PORT_BASE) begin : g_port
      assign seg_nx[s*LW +: LW] = port_sel[s-PORT_BASE]
                                  ? (port_val[s-PORT_BASE] ? LV_VDD : LV_VSS)
                                  : lcd_lv;
      // R10: a pin in port mode carries the port bit as a full-rail level
      a_r10_port: assert property (@(posedge clk) disable iff (rst)
        port_sel[s-PORT_BASE] |=> (seg_lvl_o[s*LW +: LW] ==
          ($past(port_val[s-PORT_BASE]) ? LV_VDD : LV_VSS)));
    end else begin : g_lcd
      assign seg_nx[s*LW +: LW] = lcd_lv;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      com_lvl_o <= '0;
      seg_lvl_o <= '0;
      fsync_o   <= 1'b0;
      dclk_o    <= 1'b0;
    end else begin
      com_lvl_o <= com_nx;
      seg_lvl_o <= seg_nx;
      fsync_o   <= en && (slot == '0);
      dclk_o    <= en && (cnt < CW'(CLK_DIV / 2));
    end
  end

  // R1: a disabled display grounds all commons and silences sync and clock
  a_r1_dark: assert property (@(posedge clk) disable iff (rst)
    !en |=> (com_lvl_o == '0 && !fsync_o && !dclk_o));

  // R11: a frame always starts in the high half of the display clock
  a_r11_sync_phase: assert property (@(posedge clk) disable iff (rst)
    $rose(fsync_o) |-> dclk_o);

endmodule

// File: rtl/lcd_wave_seq.sv
module lcd_wave_seq
  import lcd_seq_pkg::*;
#(
  parameter int NUM_COM  = 4,
  parameter int NUM_SEG  = 32,
  parameter int NUM_PORT = 8,
  parameter int CLK_DIV  = 8,
  localparam int AW = $clog2(NUM_SEG),
  localparam int SW = $clog2(NUM_COM),
  localparam int CW = $clog2(CLK_DIV),
  localparam int LW = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  disp_en,
  input  logic [1:0]            duty_sel,
  input  logic                  bias_third,
  input  logic                  wr_en,
  input  logic [AW-1:0]         wr_addr,
  input  logic [NUM_COM-1:0]    wr_data,
  input  logic [NUM_PORT-1:0]   port_sel,
  input  logic [NUM_PORT-1:0]   port_val,
  output logic [NUM_COM*LW-1:0] com_lvl_o,
  output logic [NUM_SEG*LW-1:0] seg_lvl_o,
  output logic                  fsync_o,
  output logic                  dclk_o
);

  scheme_t               sch;
  logic [SW-1:0]         last_slot;
  logic [CW-1:0]         cnt;
  logic [SW-1:0]         slot;
  logic                  neg;
  logic [NUM_SEG*NUM_COM-1:0] pix;

  always_comb begin
    last_slot = SW'(duty_sel);
    case (duty_sel)
      2'd0:    sch = SCH_STATIC;
      2'd1:    sch = SCH_HALF;
      2'd2:    sch = bias_third ? SCH_THIRD : SCH_HALF;
      default: sch = SCH_THIRD;
    endcase
  end

  lcd_slot_timer #(.NUM_COM(NUM_COM), .CLK_DIV(CLK_DIV)) u_timer (
    .clk(clk), .rst(rst), .run(disp_en), .last_slot(last_slot),
    .cnt(cnt), .slot(slot), .neg(neg)
  );

  lcd_disp_ram #(.NUM_SEG(NUM_SEG), .NUM_COM(NUM_COM)) u_ram (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .bits(pix)
  );

  lcd_pin_drive #(.NUM_COM(NUM_COM), .NUM_SEG(NUM_SEG), .NUM_PORT(NUM_PORT),
                  .CLK_DIV(CLK_DIV)) u_drive (
    .clk(clk), .rst(rst), .en(disp_en), .sch(sch), .last_slot(last_slot),
    .cnt(cnt), .slot(slot), .neg(neg), .pix(pix),
    .port_sel(port_sel), .port_val(port_val),
    .com_lvl_o(com_lvl_o), .seg_lvl_o(seg_lvl_o),
    .fsync_o(fsync_o), .dclk_o(dclk_o)
  );

endmodule

// File: tb/lcd_wave_seq_bench.sv
module lcd_wave_seq_bench;

  localparam int DIV = 8;

  logic        clk = 1'b0;
  logic        rst;
  logic        disp_en;
  logic [1:0]  duty_sel;
  logic        bias_third;
  logic        wr_en;
  logic [4:0]  wr_addr;
  logic [3:0]  wr_data;
  logic [7:0]  port_sel;
  logic [7:0]  port_val;
  logic [11:0] com_lvl_o;
  logic [95:0] seg_lvl_o;
  logic        fsync_o;
  logic        dclk_o;

  lcd_wave_seq u_lcd_wave_seq (
    .clk(clk), .rst(rst), .disp_en(disp_en), .duty_sel(duty_sel),
    .bias_third(bias_third), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .port_sel(port_sel), .port_val(port_val),
    .com_lvl_o(com_lvl_o), .seg_lvl_o(seg_lvl_o),
    .fsync_o(fsync_o), .dclk_o(dclk_o)
  );

  always #5 clk = ~clk;

  int nchk = 0;
  int nerr = 0;
  int pos  = 0;
  logic [3:0] shadow [32];

  task automatic check(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic adv(input int n);
    repeat (n) @(negedge clk);
    pos += n;
  endtask

  task automatic goto_pos(input int p);
    adv(p - pos);
  endtask

  function automatic int e_com(input int c, input int k, input bit ng);
    int n = int'(duty_sel) + 1;
    bit third = (duty_sel == 2'd3) || (duty_sel == 2'd2 && bias_third);
    if (!disp_en) return 0;
    if (duty_sel == 2'd0) return ng ? 0 : 3;
    if (c < n && c == k) return ng ? 0 : 3;
    if (third) return ng ? 2 : 1;
    return 2;
  endfunction

  function automatic int e_seg(input int s, input int k, input bit ng);
    bit third = (duty_sel == 2'd3) || (duty_sel == 2'd2 && bias_third);
    if (s >= 24 && port_sel[s-24]) return port_val[s-24] ? 4 : 0;
    if (!disp_en) return 0;
    if (shadow[s][k]) return ng ? 3 : 0;
    if (third) return ng ? 1 : 2;
    return ng ? 0 : 3;
  endfunction

  task automatic wr_word(input int a, input logic [3:0] d);
    wr_en = 1'b1; wr_addr = 5'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    shadow[a] = d;
  endtask

  task automatic stop_display();
    disp_en = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic start_display(input logic [1:0] d, input logic b3);
    stop_display();
    duty_sel = d; bias_third = b3; disp_en = 1'b1;
    @(negedge clk);
    pos = 0;
  endtask

  // Walk nf frames from pos 0, checking every pin mid-slot plus sync and clock.
  task automatic run_frames(input int nf, input string tag);
    int n = int'(duty_sel) + 1;
    for (int f = 0; f < nf; f++) begin
      bit ng = f[0];
      for (int k = 0; k < n; k++) begin
        int base = (f * n + k) * DIV;
        goto_pos(base + 1);
        check("R12 dclk high", int'(dclk_o), 1);
        check("R11 fsync", int'(fsync_o), int'(k == 0));
        goto_pos(base + 4);
        for (int c = 0; c < 4; c++) begin
          if (c < n) check("R2/R3 com level", int'(com_lvl_o[c*3 +: 3]), e_com(c, k, ng));
          else       check("R8 unused com", int'(com_lvl_o[c*3 +: 3]), e_com(c, k, ng));
        end
        for (int s = 0; s < 32; s++) begin
          if (s >= 24 && port_sel[s-24])
            check("R10 port pin", int'(seg_lvl_o[s*3 +: 3]), e_seg(s, k, ng));
          else
            check(tag, int'(seg_lvl_o[s*3 +: 3]), e_seg(s, k, ng));
        end
        goto_pos(base + 5);
        check("R12 dclk low", int'(dclk_o), 0);
        check("R11 fsync", int'(fsync_o), int'(k == 0));
      end
    end
  endtask

  task automatic t_reset();
    check("R1 reset com", int'(com_lvl_o), 0);
    check("R1 reset seg", int'(seg_lvl_o != '0), 0);
    check("R1 reset fsync", int'(fsync_o), 0);
    check("R1 reset dclk", int'(dclk_o), 0);
  endtask

  task automatic t_quarter();
    wr_word(0, 4'b0101);
    wr_word(5, 4'b1010);
    wr_word(17, 4'b1111);
    wr_word(31, 4'b1001);
    start_display(2'd3, 1'b0);
    run_frames(2, "R4 quarter seg");
  endtask

  task automatic t_half();
    start_display(2'd1, 1'b0);
    run_frames(2, "R5 half seg");
  endtask

  task automatic t_third();
    start_display(2'd2, 1'b1);
    run_frames(2, "R6 third bias third seg");
    start_display(2'd2, 1'b0);
    run_frames(2, "R6 third bias half seg");
  endtask

  task automatic t_static();
    start_display(2'd0, 1'b0);
    run_frames(4, "R7 static seg");
  endtask

  // Write edge coincides with the slot 0 -> slot 1 boundary.
  task automatic t_write_boundary();
    wr_word(3, 4'b0000);
    start_display(2'd3, 1'b0);
    goto_pos(DIV - 1);
    wr_en = 1'b1; wr_addr = 5'd3; wr_data = 4'b0010;
    adv(1);
    wr_en = 1'b0;
    check("R9 old data at boundary", int'(seg_lvl_o[3*3 +: 3]), 2);
    check("R2 com1 selected", int'(com_lvl_o[1*3 +: 3]), 3);
    shadow[3] = 4'b0010;
    adv(1);
    check("R9 new data next cycle", int'(seg_lvl_o[3*3 +: 3]), 0);
  endtask

  task automatic t_port();
    port_sel = 8'b1000_0001;
    port_val = 8'b1000_0000;
    start_display(2'd3, 1'b0);
    run_frames(1, "R4 seg beside port");
  endtask

  task automatic t_disable();
    start_display(2'd3, 1'b0);
    goto_pos(DIV + 2);
    disp_en = 1'b0;
    adv(1);
    check("R1 dark com", int'(com_lvl_o), 0);
    check("R1 dark fsync", int'(fsync_o), 0);
    check("R1 dark dclk", int'(dclk_o), 0);
    for (int s = 0; s < 24; s++)
      check("R1 dark seg", int'(seg_lvl_o[s*3 +: 3]), 0);
    check("R10 port seg24 dark", int'(seg_lvl_o[24*3 +: 3]), 0);
    check("R10 port seg31 dark", int'(seg_lvl_o[31*3 +: 3]), 4);
    check("R1 non-port seg30 dark", int'(seg_lvl_o[30*3 +: 3]), 0);
    port_val = 8'b0000_0001;
    adv(1);
    check("R10 port seg24 follows", int'(seg_lvl_o[24*3 +: 3]), 4);
    check("R10 port seg31 follows", int'(seg_lvl_o[31*3 +: 3]), 0);
  endtask

  initial begin
    for (int i = 0; i < 32; i++) shadow[i] = 4'b0000;
    rst = 1'b1; disp_en = 1'b0; duty_sel = 2'd0; bias_third = 1'b0;
    wr_en = 1'b0; wr_addr = '0; wr_data = '0; port_sel = '0; port_val = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_quarter();
    t_half();
    t_third();
    t_static();
    t_write_boundary();
    t_port();
    t_disable();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nchk++;
    nerr++;
    $display("FAIL R1 watchdog act=running exp=done");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule